// File: doc/BRIEF.md
# Multi-Personality Mapper Mode Controller

This block sits at the front of a cartridge controller that can behave as one of three bank-switching personalities. Core A is a plain latch-style core, core B is a scanline-counting core and core C is a serial-load core. The block holds a small mode register that the CPU loads through a partial-address decode below 0x8000. It steers every CPU write at 0x8000 and above to the write strobe of the selected core, and decodes the write enable for the 8 KB work RAM window. It also pulses a reset into core C when the mode register is written at an odd address.

The three cores run outside this block. Each one presents its four 8 KB program bank numbers and its eight 1 KB character bank numbers as input buses, and cores A and C also present a mirroring code. The block picks the active core's buses and registers them onto its outputs. It widens every character bank by one outer bit taken from the mode register. Core B takes its mirroring from a shadow bit held here, and the CPU-cycle strobe, PPU-address strobe and interrupt of core B are gated so they act only while core B is selected. Because the cores keep their state when they are not selected, switching back to a core restores its mapping on the next cycle without any new writes.

Top module: `mapper_mode_mux`

## Requirements
- R1: A CPU write with address bit 15 clear and address bits 14 and 8 both set loads data bits [2:0] into the mode register. No other write changes it.
- R2: Mode bits [1:0] select the personality: 0 selects core A, 1 selects core B, and 2 or 3 selects core C. `prg_bank` carries the selected core's four program banks, slot i at bits [i*PRG_W +: PRG_W].
- R3: Every character slot on `chr_bank` is CHR_W+1 bits wide, with slot i at bits [i*(CHR_W+1) +: CHR_W+1]. Its low CHR_W bits are the selected core's bank and its top bit is mode bit 2, in all three personalities.
- R4: `c_rst` is high, in the same cycle, exactly for a mode-register write whose address bit 0 is 1.
- R5: A write with address bit 15 set raises the write strobe of the selected core only (`a_we`, `b_we` or `c_we`). No core strobe rises for writes below 0x8000.
- R6: `wram_we` is high for a write in 0x6000–0x7FFF that does not match the mode-register decode, and low otherwise.
- R7: `b_tick_o` and `b_ppu_o` pass `cpu_tick` and `ppu_strobe` only while mode bits [1:0] equal 1. The registered `irq` equals `b_irq` sampled in mode 1 and is 0 in any other mode.
- R8: In mode 1, a write whose address AND 0xE001 equals 0xA000 stores data bit 0 in a shadow bit. In mode 1 `mirror` is 3 (horizontal) when the shadow bit is 1 and 2 (vertical) when it is 0. The shadow bit survives excursions into other modes, and writes made in those modes leave it unchanged.
- R9: Reset clears the mode register, the shadow bit and all registered outputs to 0.
- R10: `prg_bank`, `chr_bank`, `mirror` and `irq` are registered. They show the mode, shadow bit and core inputs as they stood just before the previous rising clock edge.
- R11: In modes 0, 2 and 3 `mirror` passes the selected core's 2-bit code (0 single-screen lower, 1 single-screen upper, 2 vertical, 3 horizontal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_tick | input | 1 | CPU cycle strobe |
| ppu_strobe | input | 1 | PPU address-change strobe |
| a_prg | input | 4*PRG_W | Core A program banks |
| a_chr | input | 8*CHR_W | Core A character banks |
| a_mir | input | 2 | Core A mirroring code |
| b_prg | input | 4*PRG_W | Core B program banks |
| b_chr | input | 8*CHR_W | Core B character banks |
| b_irq | input | 1 | Core B interrupt request |
| c_prg | input | 4*PRG_W | Core C program banks |
| c_chr | input | 8*CHR_W | Core C character banks |
| c_mir | input | 2 | Core C mirroring code |
| a_we | output | 1 | Write strobe to core A |
| b_we | output | 1 | Write strobe to core B |
| c_we | output | 1 | Write strobe to core C |
| c_rst | output | 1 | Reset pulse to core C |
| wram_we | output | 1 | Work RAM write enable |
| b_tick_o | output | 1 | Gated CPU cycle strobe to core B |
| b_ppu_o | output | 1 | Gated PPU strobe to core B |
| prg_bank | output | 4*PRG_W | Registered program banks |
| chr_bank | output | 8*(CHR_W+1) | Registered character banks with outer bit |
| mirror | output | 2 | Registered mirroring code |
| irq | output | 1 | Registered gated interrupt |

## Verification
Some properties are checked on every cycle. These are the exclusivity of the write strobes and the work RAM enable, the mode load from the decoded address, the tie between the reset pulse and an odd address, and the gating of core B's strobes and interrupt. The outer character bit is checked against the mode one cycle earlier, and mode 1 is checked to force a horizontal or vertical code. The bench's scenarios cover the rest. They show that the shadow bit survives a round trip through other modes, that re-entry restores core B's mapping with no new write, and that a pattern such as 0x6100 counts as a mode write rather than a work RAM write. They also check the exact registered bank values against a model under random traffic.

// File: rtl/mapper_mode_mux.sv
module mapper_mode_mux #(
  parameter int PRG_W = 8,
  parameter int CHR_W = 8,
  parameter int PRG_SLOTS = 4,
  parameter int CHR_SLOTS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cpu_wr,
  input  logic [15:0]                      cpu_addr,
  input  logic [7:0]                       cpu_wdata,
  input  logic                             cpu_tick,
  input  logic                             ppu_strobe,
  input  logic [PRG_SLOTS*PRG_W-1:0]       a_prg,
  input  logic [CHR_SLOTS*CHR_W-1:0]       a_chr,
  input  logic [1:0]                       a_mir,
  input  logic [PRG_SLOTS*PRG_W-1:0]       b_prg,
  input  logic [CHR_SLOTS*CHR_W-1:0]       b_chr,
  input  logic                             b_irq,
  input  logic [PRG_SLOTS*PRG_W-1:0]       c_prg,
  input  logic [CHR_SLOTS*CHR_W-1:0]       c_chr,
  input  logic [1:0]                       c_mir,
  output logic                             a_we,
  output logic                             b_we,
  output logic                             c_we,
  output logic                             c_rst,
  output logic                             wram_we,
  output logic                             b_tick_o,
  output logic                             b_ppu_o,
  output logic [PRG_SLOTS*PRG_W-1:0]       prg_bank,
  output logic [CHR_SLOTS*(CHR_W+1)-1:0]   chr_bank,
  output logic [1:0]                       mirror,
  output logic                             irq
);

  localparam int CO_W  = CHR_W + 1;
  localparam int PRG_T = PRG_SLOTS * PRG_W;
  localparam int CHR_T = CHR_SLOTS * CO_W;

  logic [2:0] mode_q;
  logic       shadow_q;
  logic       mode_hit, sel_a, sel_b, sel_c, shadow_hit;
  logic [PRG_T-1:0] prg_nx;
  logic [CHR_T-1:0] chr_nx;
  logic [1:0]       mir_nx;
  logic             unused_bits;

  assign mode_hit = cpu_wr & ~cpu_addr[15] & cpu_addr[14] & cpu_addr[8];
  assign sel_a    = (mode_q[1:0] == 2'd0);
  assign sel_b    = (mode_q[1:0] == 2'd1);
  assign sel_c    = mode_q[1];

  assign a_we     = cpu_wr & cpu_addr[15] & sel_a;
  assign b_we     = cpu_wr & cpu_addr[15] & sel_b;
  assign c_we     = cpu_wr & cpu_addr[15] & sel_c;
  assign c_rst    = mode_hit & cpu_addr[0];
  assign wram_we  = cpu_wr & (cpu_addr[15:13] == 3'b011) & ~mode_hit;
  assign b_tick_o = cpu_tick & sel_b;
  assign b_ppu_o  = ppu_strobe & sel_b;

  assign shadow_hit = b_we & (cpu_addr[15:13] == 3'b101) & ~cpu_addr[0];

  assign unused_bits = ^{cpu_addr[12:9], cpu_addr[7:1], cpu_wdata[7:3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      shadow_q <= 1'b0;
    end else begin
      if (mode_hit)   mode_q   <= cpu_wdata[2:0];
      if (shadow_hit) shadow_q <= cpu_wdata[0];
    end
  end

  assign prg_nx = sel_a ? a_prg : (sel_b ? b_prg : c_prg);

  for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_chr
    logic [CHR_W-1:0] src;
    assign src = sel_a ? a_chr[i*CHR_W +: CHR_W]
               : (sel_b ? b_chr[i*CHR_W +: CHR_W] : c_chr[i*CHR_W +: CHR_W]);
    assign chr_nx[i*CO_W +: CO_W] = {mode_q[2], src};
  end

  assign mir_nx = sel_a ? a_mir : (sel_b ? {1'b1, shadow_q} : c_mir);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_bank <= '0;
      chr_bank <= '0;
      mirror   <= 2'd0;
      irq      <= 1'b0;
    end else begin
      prg_bank <= prg_nx;
      chr_bank <= chr_nx;
      mirror   <= mir_nx;
      irq      <= sel_b & b_irq;
    end
  end

endmodule

// File: rtl/mapper_mode_mux_chk.sv
module mapper_mode_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic       a15,
  input logic       a14,
  input logic       a8,
  input logic       a0,
  input logic [2:0] wd,
  input logic [2:0] mode_q,
  input logic       a_we,
  input logic       b_we,
  input logic       c_we,
  input logic       c_rst,
  input logic       wram_we,
  input logic       b_tick_o,
  input logic       b_ppu_o,
  input logic       b_irq,
  input logic       irq,
  input logic       chr_top,
  input logic [1:0] mirror
);

  p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_we, b_we, c_we, wram_we, c_rst}));

  p_mode_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !a15 && a14 && a8) |=> (mode_q == $past(wd)));

  p_crst_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    c_rst |-> (a0 && cpu_wr && !a15));

  p_tick_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] != 2'd1) |-> (!b_tick_o && !b_ppu_o));

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(mode_q[1:0]) == 2'd1 && $past(b_irq)));

  p_outer_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_top == $past(mode_q[2]));

  p_mirror_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q[1:0]) == 2'd1) |-> mirror[1]);

endmodule

bind mapper_mode_mux mapper_mode_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr),
  .a15(cpu_addr[15]), .a14(cpu_addr[14]), .a8(cpu_addr[8]), .a0(cpu_addr[0]),
  .wd(cpu_wdata[2:0]), .mode_q(mode_q),
  .a_we(a_we), .b_we(b_we), .c_we(c_we), .c_rst(c_rst), .wram_we(wram_we),
  .b_tick_o(b_tick_o), .b_ppu_o(b_ppu_o), .b_irq(b_irq), .irq(irq),
  .chr_top(chr_bank[CHR_W]), .mirror(mirror)
);

// File: tb/sim_mapper_mode_mux.sv
module sim_mapper_mode_mux;
  localparam int PW = 8, CW = 8;

  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, cpu_tick = 0, ppu_strobe = 0, b_irq = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [4*PW-1:0] a_prg = 0, b_prg = 0, c_prg = 0;
  logic [8*CW-1:0] a_chr = 0, b_chr = 0, c_chr = 0;
  logic [1:0] a_mir = 0, c_mir = 0;
  logic a_we, b_we, c_we, c_rst, wram_we, b_tick_o, b_ppu_o, irq;
  logic [4*PW-1:0] prg_bank;
  logic [8*(CW+1)-1:0] chr_bank;
  logic [1:0] mirror;

  int n_chk = 0, n_bad = 0;
  logic [2:0] m_mode = 0;
  logic m_shadow = 0;
  bit have_exp = 0;
  logic [4*PW-1:0] e_prg;
  logic [8*(CW+1)-1:0] e_chr;
  logic [1:0] e_mir;
  logic e_irq;

  always #5 clk = ~clk;

  mapper_mode_mux u0 (.*);

  task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_mode_wr(bit wr, logic [15:0] ad);
    return wr && !ad[15] && ad[14] && ad[8];
  endfunction

  task automatic step(bit wr, logic [15:0] ad, logic [7:0] d);
    logic mh;
    @(negedge clk);
    if (have_exp) begin
      check("R1/R2/R10 prg_bank", 96'(prg_bank), 96'(e_prg));
      check("R3 chr_bank", 96'(chr_bank), 96'(e_chr));
      check("R8/R11 mirror", 96'(mirror), 96'(e_mir));
      check("R7 irq", 96'(irq), 96'(e_irq));
    end
    a_prg = $urandom; b_prg = $urandom; c_prg = $urandom;
    a_chr = {$urandom, $urandom}; b_chr = {$urandom, $urandom}; c_chr = {$urandom, $urandom};
    a_mir = 2'($urandom); c_mir = 2'($urandom); b_irq = 1'($urandom);
    cpu_tick = 1'($urandom); ppu_strobe = 1'($urandom);
    cpu_wr = wr; cpu_addr = ad; cpu_wdata = d;
    #1;
    mh = is_mode_wr(wr, ad);
    check("R5 a_we", 96'(a_we), 96'(wr && ad[15] && m_mode[1:0] == 0));
    check("R5 b_we", 96'(b_we), 96'(wr && ad[15] && m_mode[1:0] == 1));
    check("R5 c_we", 96'(c_we), 96'(wr && ad[15] && m_mode[1]));
    check("R4 c_rst", 96'(c_rst), 96'(mh && ad[0]));
    check("R6 wram_we", 96'(wram_we), 96'(wr && ad >= 16'h6000 && ad <= 16'h7FFF && !mh));
    check("R7 b_tick_o", 96'(b_tick_o), 96'(cpu_tick && m_mode[1:0] == 1));
    check("R7 b_ppu_o", 96'(b_ppu_o), 96'(ppu_strobe && m_mode[1:0] == 1));
    case (m_mode[1:0])
      2'd0: begin e_prg = a_prg; e_mir = a_mir; end
      2'd1: begin e_prg = b_prg; e_mir = {1'b1, m_shadow}; end
      default: begin e_prg = c_prg; e_mir = c_mir; end
    endcase
    for (int i = 0; i < 8; i++)
      e_chr[i*(CW+1) +: CW+1] = {m_mode[2],
        (m_mode[1:0] == 0) ? a_chr[i*CW +: CW] :
        (m_mode[1:0] == 1) ? b_chr[i*CW +: CW] : c_chr[i*CW +: CW]};
    e_irq = (m_mode[1:0] == 1) && b_irq;
    if (wr && ad[15] && m_mode[1:0] == 1 && (ad & 16'hE001) == 16'hA000) m_shadow = d[0];
    if (mh) m_mode = d[2:0];
    have_exp = 1;
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] r = 16'($urandom);
    case ($urandom % 6)
      0: return (r & 16'h7FFF) | 16'h4100;
      1: return 16'h6000 | (r & 16'h1FFF);
      2: return 16'h8000 | r;
      3: return 16'hA000 | (r & 16'h1FFE);
      4: return r;
      default: return r & 16'h7FFF;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset prg", 96'(prg_bank), 96'(0));
    check("R9 reset chr", 96'(chr_bank), 96'(0));
    check("R9 reset mirror", 96'(mirror), 96'(0));
    check("R9 reset irq", 96'(irq), 96'(0));
    rst_n = 1;
    step(0, 16'h0000, 8'h00);
    step(1, 16'h4000, 8'h01);
    step(1, 16'h6100, 8'h01);
    step(1, 16'hA000, 8'h01);
    step(1, 16'h4100, 8'h00);
    step(1, 16'h6000, 8'h55);
    step(1, 16'h7F01, 8'h06);
    step(1, 16'hA000, 8'h00);
    step(1, 16'h4101, 8'h05);
    step(1, 16'hA001, 8'h00);
    step(0, 16'h0000, 8'h00);
    step(1, 16'h4102, 8'h00);
    step(1, 16'h8000, 8'h00);
    for (int k = 0; k < 4000; k++)
      step(1'($urandom), pick_addr(), 8'($urandom));
    step(0, 16'h0000, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule